// File: doc/BRIEF.md
# Extended-to-Single Store Rounding Converter

This block narrows an 80-bit working-precision floating-point value to a 32-bit IEEE single-precision word, as needed when a register is written to memory in the short format. The source value arrives as three 32-bit words. Word 0 carries the sign in bit 31 and the 15-bit biased exponent (bias 16383) in bits 14:0, with bits 30:15 ignored. Word 1 carries the explicit integer bit in bit 31 and the top 31 fraction bits. Word 2 carries the low 32 fraction bits. The store path always rounds to nearest with ties to even. A value that fits the destination exactly is passed through unchanged.

Operands are accepted through a valid/ready handshake. Each accepted operand goes through a decode/normalise stage and a round/pack stage. The result is then held on the output handshake until it is taken. The block classifies zeros, infinities, quiet and signalling NaNs, normal results and denormal results. It reports four exception flags on `resFlags`: bit 0 inexact, bit 1 underflow, bit 2 overflow, bit 3 invalid. An invalid-trap enable picks between quieting a signalling NaN and flagging it for a trap.

Top module: `ext_to_single_store`

## Requirements
- R1: `inReady` is high only while the block is idle. An operand accepted at clock edge k gives `resValid` high after edge k+1 and low after edge k. The word, flags and trap bit stay stable while `resValid` is high and `resReady` is low.
- R2: A finite value that single precision represents exactly comes out with the exponent rebiased (extended exponent minus 16256) and with no flags.
- R3: Rounding is to nearest with ties to even, using the first discarded bit (word 1 bit 7) and the OR of all lower bits. A carry out of the significand increments the exponent.
- R4: If the exponent after rounding reaches 255, the output is an infinity with the input's sign, and the flags are overflow plus inexact (value 4'b0101).
- R5: A result below 2^-126 is denormalised, with exponent field 0. Bits shifted out feed the sticky bit. A result that rounds up to 2^-126 gets exponent field 1 and fraction 0.
- R6: A non-zero input that rounds to zero gives a zero with the input's sign, and the flags are underflow plus inexact (4'b0011).
- R7: Inexact (bit 0) is set whenever any discarded bit of a finite non-zero input is non-zero.
- R8: An input with exponent 0 and all 64 significand bits 0 gives a zero with the input's sign and no flags.
- R9: An input with exponent 7FFFh and fraction bits (word 1 bits 30:0 and word 2) all zero gives an infinity with the input's sign and no flags. The integer bit is ignored.
- R10: A quiet NaN input (exponent 7FFFh, word 1 bit 30 set) gives exponent FFh, fraction = word 1 bits 30:8, the input's sign and no flags.
- R11: A signalling NaN input (exponent 7FFFh, word 1 bit 30 clear, other fraction bits non-zero) with `trapInvalidEn` low sets invalid (4'b1000) and clears `resTrap`. Its output fraction has bit 22 set and bits 21:0 = word 1 bits 29:8.
- R12: A signalling NaN input with `trapInvalidEn` high sets invalid and `resTrap`. Its output fraction has bit 22 clear and bits 21:0 = word 1 bits 29:8, or 1 if those bits are all zero.
- R13: A finite input whose integer bit is clear (an unnormal value, or an extended denormal) is normalised by its leading-zero count before rounding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand words are valid |
| inReady | output | 1 | Block can accept an operand |
| inWord0 | input | 32 | Sign and 15-bit exponent |
| inWord1 | input | 32 | Integer bit and upper fraction |
| inWord2 | input | 32 | Lower fraction |
| trapInvalidEn | input | 1 | Invalid-operation trap enable, sampled with the operand |
| resValid | output | 1 | Result word is valid |
| resReady | input | 1 | Consumer takes the result |
| resWord | output | 32 | Single-precision result |
| resFlags | output | 4 | {invalid, overflow, underflow, inexact} |
| resTrap | output | 1 | Signalling NaN met with the trap enabled |

## Verification
Two pairs of functions can act on the same result. In the first pair, rounding and exponent range meet. A significand carry can push a value to exponent 255 (overflow at the same step as the round-up), and a denormal round-up can land on the smallest normal exponent. Both are provoked with all-ones significands at the boundary exponents. The expected words and flags are worked out by hand. In the second pair, the output hold of the handshake overlaps a freshly rounded result. It is provoked by keeping `resReady` low for several cycles after a rounding case, and judged by checking that the word and flags do not move while `inReady` stays low.

// File: rtl/ext2sgl_pkg.sv
package ext2sgl_pkg;
  localparam int WORD_W     = 32;
  localparam int EXT_EXP_W  = 15;
  localparam int EXT_MANT_W = 64;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int SGL_MANT_W = SGL_FRAC_W + 1;
  localparam int DROP_W     = EXT_MANT_W - SGL_MANT_W;
  localparam int EXT_BIAS   = 16383;
  localparam int SGL_BIAS   = 127;
  localparam int REBIAS     = EXT_BIAS - SGL_BIAS;
  localparam int CALC_W     = EXT_EXP_W + 3;
  localparam int LZ_W       = $clog2(EXT_MANT_W) + 1;
  localparam int SGL_EXP_MAX = (1 << SGL_EXP_W) - 1;

  localparam int FLAG_W = 4;
  localparam int FLG_NX = 0;
  localparam int FLG_UF = 1;
  localparam int FLG_OF = 2;
  localparam int FLG_IV = 3;

  typedef enum logic [2:0] {
    CLS_ZERO,
    CLS_FINITE,
    CLS_INF,
    CLS_QNAN,
    CLS_SNAN
  } valClass_e;

  typedef struct packed {
    logic captureIn;
    logic captureOut;
  } dpStrobe_t;
endpackage

// File: rtl/ext2sgl_datapath.sv
module ext2sgl_datapath
  import ext2sgl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [WORD_W-1:0]       word0,
  input  logic [WORD_W-1:0]       word1,
  input  logic [WORD_W-1:0]       word2,
  input  logic                    trapEn,
  output logic [WORD_W-1:0]       resWord,
  output logic [FLAG_W-1:0]       resFlags,
  output logic                    resTrap
);
  function automatic logic [LZ_W-1:0] countLead(input logic [EXT_MANT_W-1:0] v);
    logic [LZ_W-1:0] n;
    n = LZ_W'(EXT_MANT_W);
    for (int i = 0; i < EXT_MANT_W; i++) begin
      if (v[i]) n = LZ_W'(EXT_MANT_W - 1 - i);
    end
    return n;
  endfunction

  // ---------------- stage 1: classify and normalise ----------------
  logic                   inSign;
  logic [EXT_EXP_W-1:0]   inExp;
  logic [EXT_MANT_W-1:0]  inMant;
  logic                   fracZero;
  logic                   unusedPad;
  valClass_e              inClass;
  logic [LZ_W-1:0]        leadZeros;
  logic [EXT_MANT_W-1:0]  normMant;
  logic [EXT_EXP_W-1:0]   expAdj;
  logic signed [CALC_W-1:0] expEff;

  assign inSign    = word0[WORD_W-1];
  assign inExp     = word0[EXT_EXP_W-1:0];
  assign inMant    = {word1, word2};
  assign unusedPad = ^word0[WORD_W-2:EXT_EXP_W];
  assign fracZero  = (inMant[EXT_MANT_W-2:0] == '0);

  always_comb begin
    if (inExp == '1) begin
      if (fracZero)                    inClass = CLS_INF;
      else if (inMant[EXT_MANT_W-2])   inClass = CLS_QNAN;
      else                             inClass = CLS_SNAN;
    end else if (inMant == '0) begin
      inClass = CLS_ZERO;
    end else begin
      inClass = CLS_FINITE;
    end
  end

  assign leadZeros = countLead(inMant);
  assign normMant  = inMant << leadZeros;
  assign expAdj    = (inExp == '0) ? EXT_EXP_W'(1) : inExp;
  assign expEff    = $signed({3'b000, expAdj})
                   - $signed({{(CALC_W-LZ_W){1'b0}}, leadZeros})
                   - CALC_W'(REBIAS);

  valClass_e                clsQ;
  logic                     signQ;
  logic [EXT_MANT_W-1:0]    mantQ;
  logic signed [CALC_W-1:0] expQ;
  logic                     trapEnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clsQ    <= CLS_ZERO;
      signQ   <= 1'b0;
      mantQ   <= '0;
      expQ    <= '0;
      trapEnQ <= 1'b0;
    end else if (strobe.captureIn) begin
      clsQ    <= inClass;
      signQ   <= inSign;
      mantQ   <= (inClass == CLS_FINITE) ? normMant : inMant;
      expQ    <= expEff;
      trapEnQ <= trapEn;
    end
  end

  // ---------------- stage 2: align, round, pack ----------------
  logic                     isDenorm;
  logic signed [CALC_W-1:0] shAmt;
  logic [EXT_MANT_W-1:0]    shifted;
  logic                     shiftLost;
  logic [EXT_MANT_W-1:0]    aligned;
  logic [SGL_MANT_W-1:0]    keep;
  logic                     guardBit;
  logic                     stickyBit;
  logic                     roundUp;
  logic [SGL_MANT_W:0]      rounded;
  logic signed [CALC_W-1:0] expNorm;
  logic                     ovf;
  logic                     unf;
  logic                     lostAny;
  logic [SGL_EXP_W-1:0]     finExp;
  logic [SGL_FRAC_W-1:0]    finFrac;
  logic [SGL_FRAC_W-2:0]    nanPayload;

  assign isDenorm = (expQ < CALC_W'(1));
  assign shAmt    = CALC_W'(1) - expQ;

  always_comb begin
    if (!isDenorm) begin
      shifted   = mantQ;
      shiftLost = 1'b0;
    end else if (shAmt >= CALC_W'(EXT_MANT_W)) begin
      shifted   = '0;
      shiftLost = |mantQ;
    end else begin
      shifted   = mantQ >> shAmt[LZ_W-2:0];
      shiftLost = |(mantQ & ~({EXT_MANT_W{1'b1}} << shAmt[LZ_W-2:0]));
    end
  end

  assign aligned   = shifted;
  assign keep      = aligned[EXT_MANT_W-1:DROP_W];
  assign guardBit  = aligned[DROP_W-1];
  assign stickyBit = (|aligned[DROP_W-2:0]) | shiftLost;
  assign roundUp   = guardBit & (stickyBit | keep[0]);
  assign rounded   = {1'b0, keep} + {{SGL_MANT_W{1'b0}}, roundUp};
  assign lostAny   = guardBit | stickyBit;

  always_comb begin
    expNorm = expQ;
    finExp  = '0;
    finFrac = rounded[SGL_FRAC_W-1:0];
    ovf     = 1'b0;
    unf     = 1'b0;
    if (!isDenorm) begin
      if (rounded[SGL_MANT_W]) begin
        expNorm = expQ + CALC_W'(1);
        finFrac = '0;
      end
      ovf    = (expNorm >= CALC_W'(SGL_EXP_MAX));
      finExp = expNorm[SGL_EXP_W-1:0];
    end else begin
      finExp = {{(SGL_EXP_W-1){1'b0}}, rounded[SGL_FRAC_W]};
      unf    = (rounded == '0);
    end
  end

  assign nanPayload = mantQ[EXT_MANT_W-3:DROP_W];

  logic [WORD_W-1:0] nextWord;
  logic [FLAG_W-1:0] nextFlags;
  logic              nextTrap;

  always_comb begin
    nextWord  = '0;
    nextFlags = '0;
    nextTrap  = 1'b0;
    unique case (clsQ)
      CLS_ZERO: nextWord = {signQ, {(WORD_W-1){1'b0}}};
      CLS_INF:  nextWord = {signQ, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}};
      CLS_QNAN: nextWord = {signQ, {SGL_EXP_W{1'b1}}, mantQ[EXT_MANT_W-2:DROP_W]};
      CLS_SNAN: begin
        nextFlags[FLG_IV] = 1'b1;
        if (trapEnQ) begin
          nextTrap = 1'b1;
          nextWord = {signQ, {SGL_EXP_W{1'b1}}, 1'b0,
                      (nanPayload == '0) ? {{(SGL_FRAC_W-2){1'b0}}, 1'b1} : nanPayload};
        end else begin
          nextWord = {signQ, {SGL_EXP_W{1'b1}}, 1'b1, nanPayload};
        end
      end
      default: begin
        if (ovf) begin
          nextWord          = {signQ, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}};
          nextFlags[FLG_OF] = 1'b1;
          nextFlags[FLG_NX] = 1'b1;
        end else begin
          nextWord          = {signQ, finExp, finFrac};
          nextFlags[FLG_UF] = unf;
          nextFlags[FLG_NX] = lostAny;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resWord  <= '0;
      resFlags <= '0;
      resTrap  <= 1'b0;
    end else if (strobe.captureOut) begin
      resWord  <= nextWord;
      resFlags <= nextFlags;
      resTrap  <= nextTrap;
    end
  end

  // overflow result is always a signed infinity with inexact
  assert_ovf_is_inf_R4: assert property (@(posedge clk) disable iff (!rstN)
    resFlags[FLG_OF] |-> (resWord[WORD_W-2:0] == 31'h7F80_0000) && resFlags[FLG_NX]);
  // underflow result is always a zero magnitude
  assert_unf_is_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    resFlags[FLG_UF] |-> (resWord[WORD_W-2:0] == '0) && resFlags[FLG_NX]);
  // quieted signalling NaN keeps the quiet bit set
  assert_quieted_nan_R11: assert property (@(posedge clk) disable iff (!rstN)
    (resFlags[FLG_IV] && !resTrap) |-> (resWord[30:22] == 9'h1FF));
  // trapped NaN stays signalling and never collapses to infinity
  assert_trapped_nan_R12: assert property (@(posedge clk) disable iff (!rstN)
    resTrap |-> resFlags[FLG_IV] && !resWord[22] && (resWord[21:0] != '0));
endmodule

// File: rtl/ext2sgl_control.sv
module ext2sgl_control
  import ext2sgl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output logic      inReady,
  output logic      resValid,
  input  logic      resReady,
  output dpStrobe_t strobe
);
  typedef enum logic [1:0] {ST_IDLE, ST_ROUND, ST_HOLD} ctlState_e;
  ctlState_e state;

  assign inReady           = (state == ST_IDLE);
  assign resValid          = (state == ST_HOLD);
  assign strobe.captureIn  = inValid && (state == ST_IDLE);
  assign strobe.captureOut = (state == ST_ROUND);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE:  if (inValid) state <= ST_ROUND;
        ST_ROUND: state <= ST_HOLD;
        ST_HOLD:  if (resReady) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && resValid));
  assert_latency_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resValid) |-> $past(inValid && inReady, 2));
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady);
endmodule

// File: rtl/ext_to_single_store.sv
module ext_to_single_store
  import ext2sgl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord0,
  input  logic [WORD_W-1:0] inWord1,
  input  logic [WORD_W-1:0] inWord2,
  input  logic              trapInvalidEn,
  output logic              resValid,
  input  logic              resReady,
  output logic [WORD_W-1:0] resWord,
  output logic [FLAG_W-1:0] resFlags,
  output logic              resTrap
);
  dpStrobe_t strobe;

  ext2sgl_control u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inReady  (inReady),
    .resValid (resValid),
    .resReady (resReady),
    .strobe   (strobe)
  );

  ext2sgl_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .word0    (inWord0),
    .word1    (inWord1),
    .word2    (inWord2),
    .trapEn   (trapInvalidEn),
    .resWord  (resWord),
    .resFlags (resFlags),
    .resTrap  (resTrap)
  );

  assert_hold_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && !resReady) |=> resValid && $stable(resWord)
                                && $stable(resFlags) && $stable(resTrap));
endmodule

// File: tb/ext_to_single_store_tb.sv
module ext_to_single_store_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inWord0 = '0, inWord1 = '0, inWord2 = '0;
  logic        trapInvalidEn = 1'b0;
  logic        resValid;
  logic        resReady = 1'b1;
  logic [31:0] resWord;
  logic [3:0]  resFlags;
  logic        resTrap;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ext_to_single_store u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inWord0(inWord0), .inWord1(inWord1), .inWord2(inWord2),
    .trapInvalidEn(trapInvalidEn), .resValid(resValid), .resReady(resReady),
    .resWord(resWord), .resFlags(resFlags), .resTrap(resTrap)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one operand, verify handshake timing (R1), then compare result
  task automatic runOne(input string tag, input logic [31:0] w0, input logic [31:0] w1,
                        input logic [31:0] w2, input logic trapEn,
                        input logic [31:0] expWord, input logic [3:0] expFlags,
                        input logic expTrap);
    @(negedge clk);
    check("R1 idle ready", {31'b0, inReady}, 32'd1);
    inWord0 = w0; inWord1 = w1; inWord2 = w2; trapInvalidEn = trapEn;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check("R1 not valid after one edge", {31'b0, resValid}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R1 valid after two edges", {31'b0, resValid}, 32'd1);
    check({tag, " word"}, resWord, expWord);
    check({tag, " flags"}, {28'b0, resFlags}, {28'b0, expFlags});
    check({tag, " trap"}, {31'b0, resTrap}, {31'b0, expTrap});
    @(posedge clk);
  endtask

  task automatic testReset();
    check("R1 reset ready", {31'b0, inReady}, 32'd1);
    check("R1 reset valid", {31'b0, resValid}, 32'd0);
    check("R1 reset word", resWord, 32'h0);
  endtask

  task automatic testExact();
    runOne("R2 one", 32'h0000_3FFF, 32'h8000_0000, 32'h0, 1'b0, 32'h3F80_0000, 4'h0, 1'b0);
    runOne("R2 minus 1.5", 32'h8000_3FFF, 32'hC000_0000, 32'h0, 1'b0, 32'hBFC0_0000, 4'h0, 1'b0);
    runOne("R2 max finite", 32'h0000_407E, 32'hFFFF_FF00, 32'h0, 1'b0, 32'h7F7F_FFFF, 4'h0, 1'b0);
  endtask

  task automatic testRound();
    runOne("R3 tie even stays", 32'h0000_3FFF, 32'h8000_0080, 32'h0, 1'b0, 32'h3F80_0000, 4'h1, 1'b0);
    runOne("R3 tie odd up", 32'h0000_3FFF, 32'h8000_0180, 32'h0, 1'b0, 32'h3F80_0002, 4'h1, 1'b0);
    runOne("R7 sticky in low word", 32'h0000_3FFF, 32'h8000_0080, 32'h1, 1'b0, 32'h3F80_0001, 4'h1, 1'b0);
    runOne("R7 below half", 32'h0000_3FFF, 32'h8000_0000, 32'h1, 1'b0, 32'h3F80_0000, 4'h1, 1'b0);
    runOne("R3 carry to exponent", 32'h0000_3FFF, 32'hFFFF_FF80, 32'h0, 1'b0, 32'h4000_0000, 4'h1, 1'b0);
  endtask

  task automatic testOverflow();
    runOne("R4 carry overflow", 32'h0000_407E, 32'hFFFF_FF80, 32'h0, 1'b0, 32'h7F80_0000, 4'h5, 1'b0);
    runOne("R4 direct overflow neg", 32'h8000_407F, 32'h8000_0000, 32'h0, 1'b0, 32'hFF80_0000, 4'h5, 1'b0);
  endtask

  task automatic testDenormal();
    runOne("R5 half min normal", 32'h0000_3F80, 32'h8000_0000, 32'h0, 1'b0, 32'h0040_0000, 4'h0, 1'b0);
    runOne("R5 min denormal", 32'h0000_3F6A, 32'h8000_0000, 32'h0, 1'b0, 32'h0000_0001, 4'h0, 1'b0);
    runOne("R5 round to min normal", 32'h0000_3F80, 32'hFFFF_FFFF, 32'h0, 1'b0, 32'h0080_0000, 4'h1, 1'b0);
    runOne("R5 shifted sticky up", 32'h0000_3F69, 32'h8000_0000, 32'h1, 1'b0, 32'h0000_0001, 4'h1, 1'b0);
  endtask

  task automatic testUnderflow();
    runOne("R6 tie to zero", 32'h0000_3F69, 32'h8000_0000, 32'h0, 1'b0, 32'h0000_0000, 4'h3, 1'b0);
    runOne("R6 neg tiny", 32'h8000_3F68, 32'h8000_0000, 32'h0, 1'b0, 32'h8000_0000, 4'h3, 1'b0);
    runOne("R13 extended denormal", 32'h0000_0000, 32'h0, 32'h1, 1'b0, 32'h0000_0000, 4'h3, 1'b0);
  endtask

  task automatic testSpecials();
    runOne("R13 unnormal", 32'h0000_4000, 32'h4000_0000, 32'h0, 1'b0, 32'h3F80_0000, 4'h0, 1'b0);
    runOne("R8 neg zero", 32'h8000_0000, 32'h0, 32'h0, 1'b0, 32'h8000_0000, 4'h0, 1'b0);
    runOne("R9 pos inf", 32'h0000_7FFF, 32'h8000_0000, 32'h0, 1'b0, 32'h7F80_0000, 4'h0, 1'b0);
    runOne("R9 neg inf no J", 32'h8000_7FFF, 32'h0, 32'h0, 1'b0, 32'hFF80_0000, 4'h0, 1'b0);
    runOne("R10 quiet nan", 32'h0000_7FFF, 32'hC000_1234, 32'h0, 1'b0, 32'h7FC0_0012, 4'h0, 1'b0);
    runOne("R11 snan quieted", 32'h8000_7FFF, 32'h8000_1234, 32'h0, 1'b0, 32'hFFC0_0012, 4'h8, 1'b0);
    runOne("R11 snan low payload", 32'h0000_7FFF, 32'h8000_0000, 32'h1, 1'b0, 32'h7FC0_0000, 4'h8, 1'b0);
    runOne("R12 snan trapped", 32'h8000_7FFF, 32'h8000_1234, 32'h0, 1'b1, 32'hFF80_0012, 4'h8, 1'b1);
    runOne("R12 trapped zero payload", 32'h0000_7FFF, 32'h8000_0000, 32'h1, 1'b1, 32'h7F80_0001, 4'h8, 1'b1);
  endtask

  task automatic testStall();
    @(negedge clk);
    resReady = 1'b0;
    inWord0 = 32'h0000_407E; inWord1 = 32'hFFFF_FF80; inWord2 = 32'h0; trapInvalidEn = 1'b0;
    inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    check("R4 stalled overflow word", resWord, 32'h7F80_0000);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1 held valid", {31'b0, resValid}, 32'd1);
      check("R1 held word", resWord, 32'h7F80_0000);
      check("R1 held flags", {28'b0, resFlags}, 32'h5);
      check("R1 busy not ready", {31'b0, inReady}, 32'd0);
    end
    resReady = 1'b1;
    inValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1 released", {31'b0, resValid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    testExact();
    testRound();
    testOverflow();
    testDenormal();
    testUnderflow();
    testSpecials();
    testStall();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule